// File: doc/BRIEF.md
# BCD Real-Time Calendar with Full-Date Alarm

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours (24-hour only), day of month, month and two-digit year, where the year counts 2000 through 2099. It counts pulses of a 32.768 kHz tick enable with a prescaler and advances the calendar once per prescaler wrap. Carries ripple from seconds to years and respect month lengths and leap Februaries.

Software reaches the block through a byte-wide register port: a write strobe with address and data, and a combinational read-data bus. Besides the six time fields there are six alarm fields, a control register holding the run bit, a status register with sticky event flags and a BUSY indication, and an interrupt-enable register. A level interrupt is raised for an alarm match, for the once-per-second event, or for both.

BUSY is high during the final tick period before each calendar update. Software that sees BUSY low has at least one tick period in which the fields will not change.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 00 s, 00 min, 00 h, day 01, month 01, year 00. Control, status and interrupt enable read 0x00, every alarm field reads 0x00, and irq is low.
- R2: Byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 hold seconds, minutes, hours, day, month and year in packed BCD. Alarm fields for the same quantities sit at 0x20 to 0x34 in the same order. Each field reads back what was written.
- R3: The calendar advances by one second for every 2^PRE_W tick pulses, and only while control bit 0 is 1. With bit 0 clear, ticks leave the time unchanged.
- R4: Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. Each wrap carries one into the next field.
- R5: The day wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11; 31 for the other months; 28 for month 02, or 29 when the BCD year is divisible by 4. Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00.
- R6: Status bit 6 (alarm) is set when an update makes all six time fields equal the six alarm fields. If any single field differs, the bit is not set.
- R7: Status at 0x44 has bit 1 mirroring control bit 0. Bits 2, 3, 4 and 5 are set on each second update and on minute, hour and day carries. Writing 1 to any of bits 2 to 6 clears that bit, and writing 0 leaves it unchanged.
- R8: Status bit 0 (BUSY) is 1 exactly when the clock runs and the prescaler is at its last count. The next tick pulse then updates the time and drops BUSY.
- R9: A write to any time field loads that field and restarts the prescaler. The next update follows a full 2^PRE_W tick pulses later.
- R10: irq is high while (status bit 6 and enable bit 3) or (status bit 2 and enable bit 2). It stays high until the causing status bit is cleared.
- R11: Control at 0x40 stores only bit 0. Bit 3 (12-hour select) and every other bit are ignored and read as 0, so the hours always count 00 to 23.
- R12: Interrupt enable at 0x48 stores bits 2 and 3. The other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable pulse at the 32.768 kHz rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte address of the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong carry or a wrong month-length decision cannot be seen until the next second update. It then appears in the field read-back, one update after the boundary is crossed. The bench therefore loads the time just short of each boundary and reads all six fields after a single update. A prescaler that is off by one moves the BUSY window and the update edge by one tick. This is seen at the status port within one second of a known restart point, so BUSY and the restart are checked at exact tick counts. A bad alarm compare shows as a missing irq, or an unexpected one, on the update that reaches, or narrowly misses, the programmed date.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int PRE_W = 15,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq
);

  localparam int NF = 6;
  localparam logic [PRE_W-1:0] PRE_LAST = '1;
  localparam logic [AW-1:0] A_TEND = AW'(NF * 4);
  localparam logic [AW-1:0] A_ALM  = AW'(8'h20);
  localparam logic [AW-1:0] A_AEND = AW'(8'h20 + NF * 4);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h40);
  localparam logic [AW-1:0] A_STAT = AW'(8'h44);
  localparam logic [AW-1:0] A_IE   = AW'(8'h48);

  logic [7:0] tm  [NF];
  logic [7:0] al  [NF];
  logic [7:0] nxt [NF];
  logic [PRE_W-1:0] pre;
  logic run, alm_f;
  logic [3:0] ev;
  logic [1:0] ie;
  logic w0, w1, w2, w3, w4, match;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [7:0] roll(input logic [7:0] v, input logic en,
                                      input logic [7:0] top, input logic [7:0] base);
    if (!en) return v;
    return (v == top) ? base : bcd_inc(v);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    logic leap;
    leap = y[4] ? (y[3:0] == 4'd2 || y[3:0] == 4'd6)
                : (y[3:0] == 4'd0 || y[3:0] == 4'd4 || y[3:0] == 4'd8);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  wire aligned  = (addr[1:0] == 2'b00);
  wire time_wr  = wr_en && aligned && (addr < A_TEND);
  wire alm_wr   = wr_en && aligned && (addr >= A_ALM) && (addr < A_AEND);
  wire stat_wr  = wr_en && (addr == A_STAT);
  wire busy     = run && (pre == PRE_LAST);
  wire sec_tick = tick && busy && !time_wr;

  always_comb begin
    w0 = (tm[0] == 8'h59);
    w1 = w0 && (tm[1] == 8'h59);
    w2 = w1 && (tm[2] == 8'h23);
    w3 = w2 && (tm[3] == month_end(tm[4], tm[5]));
    w4 = w3 && (tm[4] == 8'h12);
    nxt[0] = roll(tm[0], 1'b1, 8'h59, 8'h00);
    nxt[1] = roll(tm[1], w0,   8'h59, 8'h00);
    nxt[2] = roll(tm[2], w1,   8'h23, 8'h00);
    nxt[3] = w3 ? 8'h01 : roll(tm[3], w2, 8'hFF, 8'h01);
    nxt[4] = roll(tm[4], w3,   8'h12, 8'h01);
    nxt[5] = roll(tm[5], w4,   8'h99, 8'h00);
    match = 1'b1;
    for (int i = 0; i < NF; i++)
      if (nxt[i] != al[i]) match = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) begin
        tm[i] <= (i == 3 || i == 4) ? 8'h01 : 8'h00;
        al[i] <= 8'h00;
      end
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (time_wr && addr[4:2] == 3'(i)) tm[i] <= wdata;
        else if (sec_tick)                 tm[i] <= nxt[i];
        if (alm_wr && addr[4:2] == 3'(i))  al[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre <= '0;
    else if (time_wr)        pre <= '0;
    else if (run && tick)    pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      ie    <= 2'b00;
      ev    <= 4'h0;
      alm_f <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTRL) run <= wdata[0];
      if (wr_en && addr == A_IE)   ie  <= wdata[3:2];
      ev[0] <= sec_tick         | (ev[0] & ~(stat_wr & wdata[2]));
      ev[1] <= (sec_tick & w0)  | (ev[1] & ~(stat_wr & wdata[3]));
      ev[2] <= (sec_tick & w1)  | (ev[2] & ~(stat_wr & wdata[4]));
      ev[3] <= (sec_tick & w2)  | (ev[3] & ~(stat_wr & wdata[5]));
      alm_f <= (sec_tick & match) | (alm_f & ~(stat_wr & wdata[6]));
    end
  end

  assign irq = (alm_f & ie[1]) | (ev[0] & ie[0]);

  always_comb begin
    rdata = 8'h00;
    if (aligned) begin
      for (int i = 0; i < NF; i++) begin
        if (addr < A_TEND && addr[4:2] == 3'(i)) rdata = tm[i];
        if (addr >= A_ALM && addr < A_AEND && addr[4:2] == 3'(i)) rdata = al[i];
      end
      if (addr == A_CTRL) rdata = {7'd0, run};
      if (addr == A_STAT) rdata = {1'b0, alm_f, ev, run, busy};
      if (addr == A_IE)   rdata = {4'd0, ie, 2'd0};
    end
  end

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !time_wr) |=> $stable(tm[0])); // R3
  AST_UPDATE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((tm[0] != $past(tm[0])) && !$past(time_wr)) |-> $past(busy)); // R8
  AST_BUSY_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run); // R8
  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> (pre == '0)); // R9
  AST_ALARM_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wdata[6] && !(sec_tick && match)) |=> !alm_f); // R7
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == 2'b00) |-> !irq); // R10

endmodule

// File: tb/tb_bcd_rtc.sv
`timescale 1ns/1ps
module tb_bcd_rtc;
  localparam int PW = 3;
  localparam int SEC = 1 << PW;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic irq;
  int vec = 0, fails = 0;

  bcd_rtc #(.PRE_W(PW), .AW(8)) dut (.clk, .rst_n, .tick, .wr_en, .addr, .wdata, .rdata, .irq);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vec++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v); chk(req, v, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h40, 8'h00);
    wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d);
    wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
    wr(8'h40, 8'h01);
    wr(8'h44, 8'h7C);
  endtask

  task automatic check_time(input string req, input logic [7:0] y, mo, d, h, mi, s);
    rdchk(req, 8'h00, s); rdchk(req, 8'h04, mi); rdchk(req, 8'h08, h);
    rdchk(req, 8'h0C, d); rdchk(req, 8'h10, mo); rdchk(req, 8'h14, y);
  endtask

  task automatic t_reset();
    check_time("R1 reset time", 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    rdchk("R1 ctrl", 8'h40, 8'h00);
    rdchk("R1 status", 8'h44, 8'h00);
    rdchk("R1 ie", 8'h48, 8'h00);
    rdchk("R1 alarm day", 8'h2C, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_regs();
    wr(8'h04, 8'h42); wr(8'h30, 8'h11);
    rdchk("R2 minutes readback", 8'h04, 8'h42);
    rdchk("R2 alarm month readback", 8'h30, 8'h11);
    wr(8'h40, 8'hFF); rdchk("R11 ctrl only bit0", 8'h40, 8'h01);
    wr(8'h40, 8'h08); rdchk("R11 12h bit ignored", 8'h40, 8'h00);
    wr(8'h48, 8'hFF); rdchk("R12 ie bits", 8'h48, 8'h0C);
    wr(8'h48, 8'h00);
  endtask

  task automatic t_run_stop();
    set_time(8'h24, 8'h06, 8'h05, 8'h10, 8'h20, 8'h30);
    rdchk("R7 run mirror", 8'h44, 8'h02);
    ticks(3 * SEC);
    check_time("R3 three seconds", 8'h24, 8'h06, 8'h05, 8'h10, 8'h20, 8'h33);
    wr(8'h40, 8'h00);
    ticks(3 * SEC);
    check_time("R3 stopped holds", 8'h24, 8'h06, 8'h05, 8'h10, 8'h20, 8'h33);
    rdchk("R7 run clear", 8'h44, 8'h04);
  endtask

  task automatic t_busy();
    logic [7:0] v;
    set_time(8'h24, 8'h06, 8'h05, 8'h10, 8'h20, 8'h30);
    ticks(SEC - 1);
    rd(8'h44, v); chk("R8 busy before update", v & 8'h01, 8'h01);
    rdchk("R8 not yet updated", 8'h00, 8'h30);
    ticks(1);
    rd(8'h44, v); chk("R8 busy drops", v & 8'h01, 8'h00);
    rdchk("R8 updated", 8'h00, 8'h31);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    set_time(8'h24, 8'h06, 8'h05, 8'h10, 8'h20, 8'h00);
    ticks(SEC / 2);
    wr(8'h00, 8'h30);
    ticks(SEC - 1);
    rdchk("R9 full second after write", 8'h00, 8'h30);
    rd(8'h44, v); chk("R9 busy at restart end", v & 8'h01, 8'h01);
    ticks(1);
    rdchk("R9 update after restart", 8'h00, 8'h31);
  endtask

  task automatic t_roll(input string req, input logic [7:0] y, mo, d, h, mi, s,
                        input logic [7:0] ey, emo, ed, eh, emi, es);
    set_time(y, mo, d, h, mi, s);
    ticks(SEC);
    check_time(req, ey, emo, ed, eh, emi, es);
  endtask

  task automatic t_events();
    set_time(8'h24, 8'h03, 8'h10, 8'h00, 8'h59, 8'h59);
    ticks(SEC);
    rdchk("R7 sec min hour events", 8'h44, 8'h1E);
    wr(8'h44, 8'h00); rdchk("R7 write zero keeps", 8'h44, 8'h1E);
    wr(8'h44, 8'h08); rdchk("R7 clear min only", 8'h44, 8'h16);
    set_time(8'h24, 8'h03, 8'h10, 8'h23, 8'h59, 8'h59);
    ticks(SEC);
    rdchk("R7 day event", 8'h44, 8'h3E);
  endtask

  task automatic t_alarm();
    logic [7:0] v;
    wr(8'h20, 8'h58); wr(8'h24, 8'h34); wr(8'h28, 8'h12);
    wr(8'h2C, 8'h05); wr(8'h30, 8'h06); wr(8'h34, 8'h24);
    wr(8'h48, 8'h08);
    set_time(8'h24, 8'h06, 8'h05, 8'h12, 8'h34, 8'h56);
    ticks(SEC);
    rd(8'h44, v); chk("R6 no alarm early", v & 8'h40, 8'h00);
    chk("R10 irq low early", {7'd0, irq}, 8'h00);
    ticks(SEC);
    rd(8'h44, v); chk("R6 alarm on match", v & 8'h40, 8'h40);
    chk("R10 irq on alarm", {7'd0, irq}, 8'h01);
    wr(8'h44, 8'h04);
    chk("R10 irq holds", {7'd0, irq}, 8'h01);
    wr(8'h44, 8'h40);
    rd(8'h44, v); chk("R7 alarm W1C", v & 8'h40, 8'h00);
    chk("R10 irq cleared", {7'd0, irq}, 8'h00);
    wr(8'h34, 8'h25);
    set_time(8'h24, 8'h06, 8'h05, 8'h12, 8'h34, 8'h56);
    ticks(2 * SEC);
    rd(8'h44, v); chk("R6 year mismatch no alarm", v & 8'h40, 8'h00);
    chk("R10 no irq mismatch", {7'd0, irq}, 8'h00);
    wr(8'h48, 8'h00);
  endtask

  task automatic t_timer_irq();
    set_time(8'h24, 8'h06, 8'h05, 8'h12, 8'h00, 8'h00);
    wr(8'h48, 8'h04);
    chk("R10 timer irq idle", {7'd0, irq}, 8'h00);
    ticks(SEC);
    chk("R10 timer irq set", {7'd0, irq}, 8'h01);
    wr(8'h44, 8'h04);
    chk("R10 timer irq cleared", {7'd0, irq}, 8'h00);
    wr(8'h48, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_run_stop();
    t_busy();
    t_restart();
    t_roll("R4 sec to min", 8'h24, 8'h06, 8'h05, 8'h10, 8'h20, 8'h59,
                            8'h24, 8'h06, 8'h05, 8'h10, 8'h21, 8'h00);
    t_roll("R4 hour wrap", 8'h24, 8'h06, 8'h05, 8'h23, 8'h59, 8'h59,
                           8'h24, 8'h06, 8'h06, 8'h00, 8'h00, 8'h00);
    t_roll("R4 hour carry", 8'h24, 8'h06, 8'h05, 8'h09, 8'h59, 8'h59,
                            8'h24, 8'h06, 8'h05, 8'h10, 8'h00, 8'h00);
    t_roll("R5 leap feb 28", 8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59,
                             8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00);
    t_roll("R5 leap feb 29", 8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59,
                             8'h24, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00);
    t_roll("R5 plain feb", 8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59,
                           8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00);
    t_roll("R5 april 30", 8'h24, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59,
                          8'h24, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00);
    t_roll("R5 jan 30", 8'h24, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59,
                        8'h24, 8'h01, 8'h31, 8'h00, 8'h00, 8'h00);
    t_roll("R5 year 99 wrap", 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59,
                              8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    t_events();
    t_alarm();
    t_timer_irq();
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
    $finish;
  end
endmodule